// File: doc/BRIEF.md
# Relative Branch Condition Resolver

This unit sits beside an instruction decoder. It takes one relative branch per request and decides whether the branch is taken. It also works out where execution goes next. Each request supplies:

- the bytes fetched for the instruction;
- the length the fetch stage assigned to it;
- the address of the instruction;
- the four status flags: zero, negative, overflow and carry.

One clock later the unit returns a result strobe with three fields:

- a recognised bit;
- a taken bit;
- the next program counter.

Two opcode families are handled. The first is the two-byte short family. It carries its condition in the first byte and its displacement in the second. The second is the three-byte extended family. It carries a fixed prefix byte, then a condition byte, then the displacement. An instruction that matches neither family comes back marked not recognised and not taken, so the caller can send it to another handler.

A taken branch lands at the instruction's own address plus the sign-extended displacement. This holds whatever the length. A branch that is not taken falls through by the instruction length.

Top module: `brr_resolver`

## Requirements
- R1: A request (`req_vld` high at a rising edge) produces `res_vld` high for exactly the following cycle. While no request is made, `res_vld` is low and `res_decoded`, `res_taken` and `res_next_pc` keep their values.
- R2: After reset `res_vld`, `res_decoded` and `res_taken` are 0 and `res_next_pc` is 0.
- R3: With `insn_len`=2, the signed conditions use these first bytes and are taken when their equation is true:
  - 0xC0: N xor V;
  - 0xC1: not (Z or (N xor V));
  - 0xC2: not (N xor V);
  - 0xC3: Z or (N xor V).
- R4: With `insn_len`=2, the unsigned conditions use these first bytes and are taken when their equation is true:
  - 0xC4: C;
  - 0xC5: not (C or Z);
  - 0xC6: not C;
  - 0xC7: C or Z.
- R5: With `insn_len`=2, first byte 0xCA is taken for every flag combination.
- R6: With `insn_len`=3, first byte 0xF8 and second byte as below, the branch is taken when its equation is true:
  - 0xE8: not V;
  - 0xE9: V;
  - 0xEA: not N;
  - 0xEB: N.
- R7: The displacement is the last instruction byte: `op_b1` when the length is 2, `op_b2` when it is 3. When taken, `res_next_pc` = `cur_pc` + sign-extended displacement. A byte beyond the instruction length has no effect.
- R8: When a recognised branch is not taken, `res_next_pc` = `cur_pc` + `insn_len` (2 or 3).
- R9: Any other byte pattern gives `res_decoded`=0, `res_taken`=0 and `res_next_pc` = `cur_pc` + `insn_len`. This covers another first byte, an 0xF8 prefix with another second byte, and a short code with length 3 or an extended code with length 2. Recognised branches give `res_decoded`=1.
- R10: All program-counter arithmetic wraps modulo 2^PC_W (2^32 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe for one branch |
| op_b0 | input | 8 | First instruction byte |
| op_b1 | input | 8 | Second instruction byte |
| op_b2 | input | 8 | Third instruction byte (used when the length is 3) |
| insn_len | input | 2 | Instruction length in bytes, 2 or 3 |
| cur_pc | input | PC_W | Address of the branch instruction |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| res_vld | output | 1 | Result strobe, one cycle after the request |
| res_decoded | output | 1 | Instruction recognised as a branch |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | PC_W | Next program counter |

## Verification
The assertions assume three things about the inputs:
- every request input is a known value at the edge where `req_vld` is sampled;
- `insn_len` carries 2 or 3 whenever a request is made;
- `rst_n` is held low before the first request.

Only the recognised-code checks need a sane length. The fall-through assertion instead checks the step against whatever length arrived.

The bench drives every input on the falling edge and keeps `req_vld` low during reset. It uses only lengths 2 and 3, plus mismatched family/length pairs that must fall into the unrecognised path. Flag sweeps cover all sixteen Z/N/V/C combinations for each condition.

// File: rtl/brr_pkg.sv
package brr_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_SHORT_BASE = 8'hC0;
  localparam logic [BYTE_W-1:0] OPC_ALWAYS     = 8'hCA;
  localparam logic [BYTE_W-1:0] OPC_EXT_PREFIX = 8'hF8;
  localparam logic [BYTE_W-1:0] OPC_EXT_BASE   = 8'hE8;
  localparam int               SHORT_CODES    = 8;
  localparam int               EXT_CODES      = 4;

  typedef enum logic [3:0] {
    COND_LT   = 4'd0,
    COND_GT   = 4'd1,
    COND_GE   = 4'd2,
    COND_LE   = 4'd3,
    COND_CS   = 4'd4,
    COND_HI   = 4'd5,
    COND_CC   = 4'd6,
    COND_LS   = 4'd7,
    COND_VC   = 4'd8,
    COND_VS   = 4'd9,
    COND_NC   = 4'd10,
    COND_NS   = 4'd11,
    COND_RA   = 4'd12,
    COND_NONE = 4'd15
  } cond_e;

  // Truth of a condition for a given flag set.
  function automatic logic cond_holds(cond_e c, logic z, logic n, logic v, logic cy);
    logic sgn_lt;
    logic uns_ls;
    sgn_lt = n ^ v;
    uns_ls = cy | z;
    case (c)
      COND_LT: cond_holds = sgn_lt;
      COND_GE: cond_holds = ~sgn_lt;
      COND_LE: cond_holds = z | sgn_lt;
      COND_GT: cond_holds = ~(z | sgn_lt);
      COND_CS: cond_holds = cy;
      COND_CC: cond_holds = ~cy;
      COND_LS: cond_holds = uns_ls;
      COND_HI: cond_holds = ~uns_ls;
      COND_VC: cond_holds = ~v;
      COND_VS: cond_holds = v;
      COND_NC: cond_holds = ~n;
      COND_NS: cond_holds = n;
      COND_RA: cond_holds = 1'b1;
      default: cond_holds = 1'b0;
    endcase
  endfunction

  // Sign extension of a byte to an arbitrary width (w >= BYTE_W).
  function automatic logic [63:0] sext_byte(logic [BYTE_W-1:0] b);
    sext_byte = {{(64-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

endpackage

// File: rtl/brr_decode.sv
module brr_decode
  import brr_pkg::*;
(
  input  logic [BYTE_W-1:0] op_b0,
  input  logic [BYTE_W-1:0] op_b1,
  input  logic [1:0]        insn_len,
  output cond_e             dec_cond,
  output logic              dec_ok
);

  logic [SHORT_CODES-1:0] short_hit;
  logic [EXT_CODES-1:0]   ext_hit;
  logic                   len_short;
  logic                   len_ext;
  logic                   is_always;

  assign len_short = (insn_len == 2'd2);
  assign len_ext   = (insn_len == 2'd3);
  assign is_always = len_short && (op_b0 == OPC_ALWAYS);

  // The short codes 0xC0..0xC7 map to conditions 0..7 in order.
  for (genvar gi = 0; gi < SHORT_CODES; gi++) begin : g_short
    assign short_hit[gi] = len_short && (op_b0 == OPC_SHORT_BASE + BYTE_W'(gi));
  end

  // The extended codes 0xF8 0xE8..0xEB map to conditions 8..11.
  for (genvar gj = 0; gj < EXT_CODES; gj++) begin : g_ext
    assign ext_hit[gj] = len_ext && (op_b0 == OPC_EXT_PREFIX) &&
                         (op_b1 == OPC_EXT_BASE + BYTE_W'(gj));
  end

  always_comb begin
    dec_cond = COND_NONE;
    for (int k = 0; k < SHORT_CODES; k++) begin
      if (short_hit[k]) dec_cond = cond_e'(4'(k));
    end
    for (int k = 0; k < EXT_CODES; k++) begin
      if (ext_hit[k]) dec_cond = cond_e'(4'(SHORT_CODES + k));
    end
    if (is_always) dec_cond = COND_RA;
  end

  assign dec_ok = (|short_hit) | (|ext_hit) | is_always;

endmodule

// File: rtl/brr_cond.sv
module brr_cond
  import brr_pkg::*;
(
  input  cond_e dec_cond,
  input  logic  dec_ok,
  input  logic  flag_z,
  input  logic  flag_n,
  input  logic  flag_v,
  input  logic  flag_c,
  output logic  take_now
);

  logic cond_true;

  assign cond_true = cond_holds(dec_cond, flag_z, flag_n, flag_v, flag_c);
  assign take_now  = dec_ok & cond_true;

endmodule

// File: rtl/brr_target.sv
module brr_target
  import brr_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [BYTE_W-1:0] disp_byte,
  input  logic [1:0]        insn_len,
  output logic [PC_W-1:0]   tgt_pc,
  output logic [PC_W-1:0]   seq_pc
);

  localparam int EXT_W = 64;

  logic [EXT_W-1:0] disp_wide;
  logic [PC_W-1:0]  disp_ext;

  assign disp_wide = sext_byte(disp_byte);
  assign disp_ext  = disp_wide[PC_W-1:0];

  // Both sums drop their carry out, giving wrap modulo 2^PC_W.
  assign tgt_pc = cur_pc + disp_ext;
  assign seq_pc = cur_pc + PC_W'(insn_len);

  logic unused_hi;
  assign unused_hi = ^disp_wide[EXT_W-1:PC_W];

endmodule

// File: rtl/brr_resolver.sv
module brr_resolver
  import brr_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [7:0]        op_b0,
  input  logic [7:0]        op_b1,
  input  logic [7:0]        op_b2,
  input  logic [1:0]        insn_len,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_c,
  output logic              res_vld,
  output logic              res_decoded,
  output logic              res_taken,
  output logic [PC_W-1:0]   res_next_pc
);

  cond_e             dec_cond;
  logic              dec_ok;
  logic              take_now;
  logic [BYTE_W-1:0] disp_byte;
  logic [PC_W-1:0]   tgt_pc;
  logic [PC_W-1:0]   seq_pc;
  logic [PC_W-1:0]   next_pc_now;

  // The displacement is always the final byte of the instruction.
  assign disp_byte = (insn_len == 2'd3) ? op_b2 : op_b1;

  brr_decode u_decode (
    .op_b0    (op_b0),
    .op_b1    (op_b1),
    .insn_len (insn_len),
    .dec_cond (dec_cond),
    .dec_ok   (dec_ok)
  );

  brr_cond u_cond (
    .dec_cond (dec_cond),
    .dec_ok   (dec_ok),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .take_now (take_now)
  );

  brr_target #(.PC_W(PC_W)) u_target (
    .cur_pc    (cur_pc),
    .disp_byte (disp_byte),
    .insn_len  (insn_len),
    .tgt_pc    (tgt_pc),
    .seq_pc    (seq_pc)
  );

  assign next_pc_now = take_now ? tgt_pc : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld     <= 1'b0;
      res_decoded <= 1'b0;
      res_taken   <= 1'b0;
      res_next_pc <= '0;
    end else begin
      res_vld <= req_vld;
      if (req_vld) begin
        res_decoded <= dec_ok;
        res_taken   <= take_now;
        res_next_pc <= next_pc_now;
      end
    end
  end

endmodule

// File: rtl/brr_resolver_chk.sv
module brr_resolver_chk
  import brr_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_vld,
  input logic [1:0]      insn_len,
  input logic [PC_W-1:0] cur_pc,
  input logic            flag_n,
  input logic            flag_v,
  input logic            flag_c,
  input logic            res_vld,
  input logic            res_decoded,
  input logic            res_taken,
  input logic [PC_W-1:0] res_next_pc,
  input cond_e           dec_cond,
  input logic            dec_ok,
  input logic            take_now,
  input logic [PC_W-1:0] tgt_pc,
  input logic [PC_W-1:0] seq_pc
);

  AST_REQ_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld && $stable(res_next_pc) && $stable(res_taken) &&
                 $stable(res_decoded)); // R1

  AST_UNDECODED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && !res_decoded |-> !res_taken); // R9

  AST_DECODE_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_decoded == $past(dec_ok)); // R9

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && dec_ok && dec_cond == COND_RA |=> res_taken); // R5

  AST_LT_EQUATION: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && dec_ok && dec_cond == COND_LT |=>
      res_taken == ($past(flag_n) != $past(flag_v))); // R3

  AST_CS_EQUATION: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && dec_ok && dec_cond == COND_CS |=> res_taken == $past(flag_c)); // R4

  AST_VS_EQUATION: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && dec_ok && dec_cond == COND_VS |=> res_taken == $past(flag_v)); // R6

  AST_NEXT_PC_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_next_pc == ($past(take_now) ? $past(tgt_pc) : $past(seq_pc))); // R7

  AST_FALLTHROUGH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && !take_now |=>
      (res_next_pc - $past(cur_pc)) == PC_W'($past(insn_len))); // R8

endmodule

bind brr_resolver brr_resolver_chk #(.PC_W(PC_W)) i_chk (.*);

// File: tb/test_brr_resolver.sv
module test_brr_resolver;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_vld = 1'b0;
  logic [7:0]      op_b0 = '0, op_b1 = '0, op_b2 = '0;
  logic [1:0]      insn_len = 2'd2;
  logic [PC_W-1:0] cur_pc = '0;
  logic            flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic            res_vld, res_decoded, res_taken;
  logic [PC_W-1:0] res_next_pc;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  brr_resolver #(.PC_W(PC_W)) i_brr_resolver (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
    .op_b0(op_b0), .op_b1(op_b1), .op_b2(op_b2), .insn_len(insn_len),
    .cur_pc(cur_pc), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .flag_c(flag_c), .res_vld(res_vld), .res_decoded(res_decoded),
    .res_taken(res_taken), .res_next_pc(res_next_pc)
  );

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Independent model: returns recognised and taken for a byte pattern.
  task automatic model(input logic [7:0] b0, input logic [7:0] b1, input logic [1:0] len,
                       input logic [3:0] f, output logic known, output logic tk);
    logic z, n, v, c;
    {z, n, v, c} = f;
    known = 1'b1;
    tk    = 1'b0;
    if (len == 2 && b0 == 8'hC0)      tk = (n != v);
    else if (len == 2 && b0 == 8'hC1) tk = !z && (n == v);
    else if (len == 2 && b0 == 8'hC2) tk = (n == v);
    else if (len == 2 && b0 == 8'hC3) tk = z || (n != v);
    else if (len == 2 && b0 == 8'hC4) tk = c;
    else if (len == 2 && b0 == 8'hC5) tk = !c && !z;
    else if (len == 2 && b0 == 8'hC6) tk = !c;
    else if (len == 2 && b0 == 8'hC7) tk = c || z;
    else if (len == 2 && b0 == 8'hCA) tk = 1'b1;
    else if (len == 3 && b0 == 8'hF8 && b1 == 8'hE8) tk = !v;
    else if (len == 3 && b0 == 8'hF8 && b1 == 8'hE9) tk = v;
    else if (len == 3 && b0 == 8'hF8 && b1 == 8'hEA) tk = !n;
    else if (len == 3 && b0 == 8'hF8 && b1 == 8'hEB) tk = n;
    else known = 1'b0;
  endtask

  // Issue one request, then check the result one cycle later.
  task automatic branch(string req, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [1:0] len,
                        input logic [PC_W-1:0] pc, input logic [3:0] f);
    logic known, tk;
    logic [7:0] d;
    logic [PC_W-1:0] exp_pc;
    model(b0, b1, len, f, known, tk);
    d = (len == 3) ? b2 : b1;
    if (tk) exp_pc = pc + {{(PC_W-8){d[7]}}, d};
    else    exp_pc = pc + PC_W'(len);
    @(negedge clk);
    req_vld = 1'b1; op_b0 = b0; op_b1 = b1; op_b2 = b2; insn_len = len; cur_pc = pc;
    {flag_z, flag_n, flag_v, flag_c} = f;
    @(negedge clk);
    req_vld = 1'b0;
    check(req, "res_vld", 64'(res_vld), 64'd1);
    check(req, "res_decoded", 64'(res_decoded), 64'(known));
    check(req, "res_taken", 64'(res_taken), 64'(tk));
    check(req, "res_next_pc", 64'(res_next_pc), 64'(exp_pc));
  endtask

  task automatic t_reset();
    check("R2", "res_vld", 64'(res_vld), 64'd0);
    check("R2", "res_decoded", 64'(res_decoded), 64'd0);
    check("R2", "res_taken", 64'(res_taken), 64'd0);
    check("R2", "res_next_pc", 64'(res_next_pc), 64'd0);
  endtask

  task automatic t_signed();  // R3
    for (int op = 0; op < 4; op++)
      for (int f = 0; f < 16; f++)
        branch("R3", 8'hC0 + 8'(op), 8'h10, 8'hEE, 2'd2, 32'h0000_4000, 4'(f));
  endtask

  task automatic t_unsigned();  // R4
    for (int op = 4; op < 8; op++)
      for (int f = 0; f < 16; f++)
        branch("R4", 8'hC0 + 8'(op), 8'hF0, 8'h33, 2'd2, 32'h0001_0000, 4'(f));
  endtask

  task automatic t_always();  // R5
    for (int f = 0; f < 16; f++)
      branch("R5", 8'hCA, 8'h22, 8'h00, 2'd2, 32'h0000_0100, 4'(f));
  endtask

  task automatic t_extended();  // R6
    for (int op = 0; op < 4; op++)
      for (int f = 0; f < 16; f++)
        branch("R6", 8'hF8, 8'hE8 + 8'(op), 8'hFC, 2'd3, 32'h0002_0000, 4'(f));
  endtask

  task automatic t_disp();  // R7
    branch("R7", 8'hCA, 8'h7F, 8'h80, 2'd2, 32'h0000_1000, 4'h0);
    check("R7", "pos max", 64'(res_next_pc), 64'h107F);
    branch("R7", 8'hCA, 8'h80, 8'h7F, 2'd2, 32'h0000_1000, 4'h0);
    check("R7", "neg max", 64'(res_next_pc), 64'h0F80);
    branch("R7", 8'hCA, 8'h00, 8'h55, 2'd2, 32'h0000_1000, 4'h0);
    check("R7", "zero disp", 64'(res_next_pc), 64'h1000);
    branch("R7", 8'hF8, 8'hEB, 8'hFF, 2'd3, 32'h0000_1000, 4'b0100);
    check("R7", "ext last byte", 64'(res_next_pc), 64'h0FFF);
  endtask

  task automatic t_fall();  // R8
    branch("R8", 8'hC4, 8'h40, 8'h00, 2'd2, 32'h0000_2000, 4'b0000);
    check("R8", "short step", 64'(res_next_pc), 64'h2002);
    branch("R8", 8'hF8, 8'hE9, 8'h40, 2'd3, 32'h0000_2000, 4'b0000);
    check("R8", "ext step", 64'(res_next_pc), 64'h2003);
  endtask

  task automatic t_unknown();  // R9
    branch("R9", 8'hC8, 8'h10, 8'h00, 2'd2, 32'h0000_3000, 4'hF);
    branch("R9", 8'hF8, 8'hEC, 8'h10, 2'd3, 32'h0000_3000, 4'hF);
    branch("R9", 8'hCA, 8'h10, 8'h10, 2'd3, 32'h0000_3000, 4'hF);
    branch("R9", 8'hF8, 8'hE9, 8'h10, 2'd2, 32'h0000_3000, 4'hF);
    check("R9", "undecoded step", 64'(res_next_pc), 64'h3002);
  endtask

  task automatic t_wrap();  // R10
    branch("R10", 8'hCA, 8'h01, 8'h00, 2'd2, 32'hFFFF_FFFF, 4'h0);
    check("R10", "wrap up", 64'(res_next_pc), 64'h0);
    branch("R10", 8'hCA, 8'h80, 8'h00, 2'd2, 32'h0000_0001, 4'h0);
    check("R10", "wrap down", 64'(res_next_pc), 64'hFFFF_FF81);
    branch("R10", 8'hF8, 8'hE9, 8'h10, 2'd3, 32'hFFFF_FFFE, 4'h0);
    check("R10", "wrap fall", 64'(res_next_pc), 64'h1);
  endtask

  task automatic t_hold();  // R1
    logic [PC_W-1:0] pc_was;
    logic tk_was, dk_was;
    branch("R1", 8'hCA, 8'h08, 8'h00, 2'd2, 32'h0000_5000, 4'h0);
    pc_was = res_next_pc; tk_was = res_taken; dk_was = res_decoded;
    @(negedge clk);
    op_b0 = 8'hC8; cur_pc = 32'h1234_5678; insn_len = 2'd3; flag_c = 1'b1;
    @(negedge clk);
    check("R1", "idle res_vld", 64'(res_vld), 64'd0);
    check("R1", "held next_pc", 64'(res_next_pc), 64'(pc_was));
    check("R1", "held taken", 64'(res_taken), 64'(tk_was));
    check("R1", "held decoded", 64'(res_decoded), 64'(dk_was));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_signed();
    t_unsigned();
    t_always();
    t_extended();
    t_disp();
    t_fall();
    t_unknown();
    t_wrap();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule